// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block conditions the second operand of an integer datapath on its way into the adder and logic unit. In the same cycle, with no register on the path, it shifts or rotates a word by a variable amount. It also produces a shifter carry-out that the surrounding datapath can load into its carry flag when a logical operation is performed. The carry flag already held in the datapath enters the block as an input. That input is returned as the carry-out when no shift takes place, and it becomes the new top bit in the one-place rotate-through-carry mode.

Five shift kinds are supported: left logical, right logical, right arithmetic, right rotate, and a 33-bit rotate by one place through the carry. The shift amount port is wider than the number of bit positions in the word, so the behaviour for shifts of exactly the word width and for larger shifts is defined. Shifts are useful as cheap multiplies. A left shift by 2 multiplies by four, and adding a register to itself shifted left by 1 gives three times its value.

Top module: `opnd_shifter`

## Requirements
- R1: With kind code 0 (left logical), 1 (right logical), 2 (right arithmetic) or 3 (right rotate) and an amount of 0, res_o equals opnd_i and cout_o equals cin_i.
- R2: Kind code 0 with an amount k from 1 to 31 gives opnd_i shifted left by k with zeros filled in at the bottom, and cout_o = opnd_i[32-k]. A shift by 2 of 5 therefore gives 20.
- R3: Kind code 1 with an amount k from 1 to 31 gives opnd_i shifted right by k with zeros filled in at the top, and cout_o = opnd_i[k-1].
- R4: Kind code 2 with an amount k from 1 to 31 shifts right by k and fills each vacated top position with opnd_i[31], and cout_o = opnd_i[k-1].
- R5: Kind code 3 with an amount k from 1 to 31 rotates right by k, so that bits leaving bit 0 re-enter at bit 31. cout_o equals the new res_o[31].
- R6: Kind code 4 gives res_o = {cin_i, opnd_i[31:1]} and cout_o = opnd_i[0], whatever the amount.
- R7: Kind codes 0 and 1 with an amount of exactly 32 give res_o = 0. cout_o = opnd_i[0] for the left shift and opnd_i[31] for the right shift.
- R8: Kind codes 0 and 1 with an amount above 32 give res_o = 0 and cout_o = 0.
- R9: Kind code 2 with an amount of 32 or more sets every bit of res_o and cout_o to opnd_i[31].
- R10: Kind code 3 with an amount of 32 or more rotates by the amount modulo 32. When that remainder is 0, res_o = opnd_i and cout_o = opnd_i[31].
- R11: Kind codes 5, 6 and 7 pass opnd_i through unchanged and give cout_o = cin_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | DATA_W (32) | Operand word to be shifted |
| kind_i | input | 3 | Shift kind code (0 left logical, 1 right logical, 2 right arithmetic, 3 right rotate, 4 rotate through carry) |
| amt_i | input | AMT_W (8) | Unsigned shift amount |
| cin_i | input | 1 | Current carry flag |
| res_o | output | DATA_W (32) | Shifted operand |
| cout_o | output | 1 | Shifter carry-out |

## Verification
Each of the eight kind codes is driven across amounts chosen around the edges of the word: 0, 1, 2, 15, 31, 32, 33, 40, 63, 64, 200 and 255. Several operand patterns are used, with the carry input at both values. A word with only its end bits set shows whether the carry is taken from the correct end. The alternating pattern exposes a shift off by one position. Words of all ones and all zeros tell sign fill apart from zero fill. Hand-computed cases pin down the multiply-by-four shift and the rotate through carry with a nonzero amount present, as well as the remainder-zero rotate and the shifts of exactly 32.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;
endpackage

// File: rtl/shf_rcore.sv
// Right-shift core on a (2W+1)-bit frame {fill, data, carry}.
// The low W+1 bits of the result are {shifted data, last bit out}.
module shf_rcore #(
   parameter int W      = 32,
   parameter bit STAGED = 1'b1
) (
   input  logic [2*W:0]           x_i,
   input  logic [$clog2(W+1)-1:0] s_i,
   output logic [W:0]             y_o
);
   localparam int SW = $clog2(W + 1);
   localparam int XW = 2 * W + 1;

   generate
      if (STAGED) begin : g_staged
         logic [SW:0][XW-1:0] st;
         assign st[0] = x_i;
         for (genvar i = 0; i < SW; i++) begin : g_stage
            assign st[i+1] = s_i[i] ? (st[i] >> (1 << i)) : st[i];
         end
         assign y_o = st[SW][W:0];
      end else begin : g_flat
         logic [XW-1:0] sh;
         assign sh  = x_i >> s_i;
         assign y_o = sh[W:0];
      end
   endgenerate

   always_comb begin
      if (!$isunknown(s_i)) begin
         AST_CORE_SPAN: assert (int'(s_i) <= W); // R10
      end
   end
endmodule

// File: rtl/shf_rrx.sv
module shf_rrx #(
   parameter int W = 32
) (
   input  logic [W-1:0] d_i,
   input  logic         cin_i,
   output logic [W-1:0] r_o,
   output logic         cout_o
);
   assign r_o    = {cin_i, d_i[W-1:1]};
   assign cout_o = d_i[0];
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   parameter bit STAGED = 1'b1
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [2:0]        kind_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o
);
   localparam int SW = $clog2(DATA_W + 1);
   localparam int LW = $clog2(DATA_W);
   localparam int XW = 2 * DATA_W + 1;

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("opnd_shifter: DATA_W must be a power of two of at least 2");
      end
      if (AMT_W < SW) begin : g_bad_amt
         $error("opnd_shifter: AMT_W too narrow to express a full-width shift");
      end
   endgenerate

   shift_kind_e       kind;
   logic [DATA_W-1:0] opnd_rev;
   logic [XW-1:0]     core_x;
   logic [SW-1:0]     core_s;
   logic [DATA_W:0]   core_y;
   logic [DATA_W-1:0] core_res;
   logic [DATA_W-1:0] core_res_rev;
   logic [DATA_W-1:0] rrx_res;
   logic              rrx_cout;
   logic              rev_sel;
   logic              force_zero;
   logic              amt_zero;
   logic              amt_over;
   logic              amt_full;
   logic [LW-1:0]     ror_mod;

   assign kind     = shift_kind_e'(kind_i);
   assign opnd_rev = {<<{opnd_i}};
   assign amt_zero = (amt_i == '0);
   assign amt_over = (amt_i > AMT_W'(DATA_W));
   assign amt_full = (amt_i >= AMT_W'(DATA_W));
   assign ror_mod  = amt_i[LW-1:0];

   // Operand framing and amount selection for the shared right-shift core
   always_comb begin
      core_x     = {{DATA_W{1'b0}}, opnd_i, cin_i};
      core_s     = '0;
      rev_sel    = 1'b0;
      force_zero = 1'b0;
      case (kind)
         SK_LSL: begin
            core_x  = {{DATA_W{1'b0}}, opnd_rev, cin_i};
            rev_sel = 1'b1;
            if (amt_over) force_zero = 1'b1;
            else          core_s     = amt_i[SW-1:0];
         end
         SK_LSR: begin
            if (amt_over) force_zero = 1'b1;
            else          core_s     = amt_i[SW-1:0];
         end
         SK_ASR: begin
            core_x = {{DATA_W{opnd_i[DATA_W-1]}}, opnd_i, cin_i};
            core_s = amt_full ? SW'(DATA_W) : amt_i[SW-1:0];
         end
         SK_ROR: begin
            core_x = {opnd_i, opnd_i, cin_i};
            if (amt_zero)             core_s = '0;
            else if (ror_mod == '0)   core_s = SW'(DATA_W);
            else                      core_s = SW'(ror_mod);
         end
         default: ;
      endcase
   end

   shf_rcore #(.W(DATA_W), .STAGED(STAGED)) u_core (
      .x_i (core_x),
      .s_i (core_s),
      .y_o (core_y)
   );

   shf_rrx #(.W(DATA_W)) u_rrx (
      .d_i    (opnd_i),
      .cin_i  (cin_i),
      .r_o    (rrx_res),
      .cout_o (rrx_cout)
   );

   assign core_res     = core_y[DATA_W:1];
   assign core_res_rev = {<<{core_res}};

   always_comb begin
      if (kind == SK_RRX) begin
         res_o  = rrx_res;
         cout_o = rrx_cout;
      end else if (force_zero) begin
         res_o  = '0;
         cout_o = 1'b0;
      end else if (rev_sel) begin
         res_o  = core_res_rev;
         cout_o = core_y[0];
      end else begin
         res_o  = core_res;
         cout_o = core_y[0];
      end
   end

   always_comb begin
      if (!$isunknown({kind_i, amt_i, opnd_i, cin_i, res_o, cout_o})) begin
         if (kind_i != 3'd4 && amt_zero) begin
            AST_ZERO_PASS: assert (res_o == opnd_i && cout_o == cin_i); // R1
         end
         if (kind_i == 3'd1 && !amt_zero && !amt_over) begin
            AST_LSR_TOP_CLEAR: assert (!res_o[DATA_W-1]); // R3
         end
         if (kind_i == 3'd2 && amt_full) begin
            AST_ASR_SATURATE: assert (res_o == {DATA_W{opnd_i[DATA_W-1]}} && cout_o == opnd_i[DATA_W-1]); // R9
         end
         if (kind_i == 3'd3) begin
            AST_ROR_KEEPS_ONES: assert ($countones(res_o) == $countones(opnd_i)); // R5
         end
         if (kind_i == 3'd4) begin
            AST_RRX_CARRY_IN: assert (res_o[DATA_W-1] == cin_i && cout_o == opnd_i[0]); // R6
         end
      end
   end
endmodule

// File: tb/sim_opnd_shifter.sv
`timescale 1ns/1ps
module sim_opnd_shifter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opnd;
   logic [2:0]  kind;
   logic [7:0]  amt;
   logic        cin;
   logic [31:0] res;
   logic        cout;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done  = 1'b0;

   typedef struct {
      logic [32:0] exp;
      logic [2:0]  k;
      logic [31:0] a;
      logic [7:0]  n;
      logic        c;
      string       req;
   } item_t;
   item_t sbq[$];

   always #5 clk = ~clk;

   opnd_shifter u0 (
      .opnd_i (opnd), .kind_i (kind), .amt_i (amt), .cin_i (cin),
      .res_o  (res),  .cout_o (cout)
   );

   // Independent reference: wide arithmetic, returns {carry, result}
   function automatic logic [32:0] ref_f(logic [2:0] k, logic [31:0] a, logic [7:0] n, logic c);
      logic [63:0] w;
      logic [31:0] r;
      int          m;
      if (k == 3'd4) return {a[0], c, a[31:1]};
      if (k > 3'd4 || n == 8'd0) return {c, a};
      case (k)
         3'd0: begin
            if (n > 8'd32) return 33'd0;
            w = {32'd0, a} << n;
            return {w[32], w[31:0]};
         end
         3'd1: begin
            if (n > 8'd32) return 33'd0;
            w = {a, 32'd0} >> n;
            return {w[31], w[63:32]};
         end
         3'd2: begin
            m = (n > 8'd32) ? 32 : int'(n);
            w = $signed({a, 32'd0}) >>> m;
            return {w[31], w[63:32]};
         end
         default: begin
            m = int'(n) % 32;
            r = (a >> m) | (a << (32 - m));
            return {r[31], r};
         end
      endcase
   endfunction

   function automatic string req_of(logic [2:0] k, logic [7:0] n);
      if (k > 3'd4)  return "R11";
      if (k == 3'd4) return "R6";
      if (n == 8'd0) return "R1";
      case (k)
         3'd0:    return (n < 8'd32) ? "R2" : (n == 8'd32) ? "R7" : "R8";
         3'd1:    return (n < 8'd32) ? "R3" : (n == 8'd32) ? "R7" : "R8";
         3'd2:    return (n < 8'd32) ? "R4" : "R9";
         default: return (n < 8'd32) ? "R5" : "R10";
      endcase
   endfunction

   task automatic drive(input logic [2:0] k, input logic [31:0] a, input logic [7:0] n,
                        input logic c, input logic [32:0] exp, input string req);
      item_t it;
      @(posedge clk);
      #1;
      kind = k; opnd = a; amt = n; cin = c;
      it.exp = exp; it.k = k; it.a = a; it.n = n; it.c = c; it.req = req;
      sbq.push_back(it);
   endtask

   // Monitor: compares in the middle of the cycle
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         n_chk++;
         if ({cout, res} !== it.exp) begin
            n_err++;
            $display("FAIL %s: kind=%0d a=%h amt=%0d cin=%b got cout=%b res=%h expected cout=%b res=%h",
                     it.req, it.k, it.a, it.n, it.c, cout, res, it.exp[32], it.exp[31:0]);
         end
      end
   end

   logic [31:0] pats [5] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'h0000_0000};
   logic [7:0]  amts [12] = '{8'd0, 8'd1, 8'd2, 8'd15, 8'd31, 8'd32, 8'd33, 8'd40, 8'd63, 8'd64, 8'd200, 8'd255};

   initial begin
      opnd = '0; kind = '0; amt = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Idle state: zero amount passes the operand through (R1)
      drive(3'd0, 32'h1234_5678, 8'd0, 1'b1, {1'b1, 32'h1234_5678}, "R1");
      // Directed cases
      drive(3'd0, 32'h0000_0005, 8'd2,  1'b0, {1'b0, 32'h0000_0014}, "R2");
      drive(3'd0, 32'h8000_0003, 8'd1,  1'b0, {1'b1, 32'h0000_0006}, "R2");
      drive(3'd1, 32'h0000_001F, 8'd4,  1'b0, {1'b1, 32'h0000_0001}, "R3");
      drive(3'd2, 32'h8000_0000, 8'd4,  1'b1, {1'b0, 32'hF800_0000}, "R4");
      drive(3'd3, 32'h1234_5678, 8'd8,  1'b1, {1'b0, 32'h7812_3456}, "R5");
      drive(3'd4, 32'h0000_0003, 8'd17, 1'b1, {1'b1, 32'h8000_0001}, "R6");
      drive(3'd1, 32'h8000_0000, 8'd32, 1'b0, {1'b1, 32'h0000_0000}, "R7");
      drive(3'd0, 32'h0000_0001, 8'd32, 1'b0, {1'b1, 32'h0000_0000}, "R7");
      drive(3'd0, 32'hFFFF_FFFF, 8'd33, 1'b1, {1'b0, 32'h0000_0000}, "R8");
      drive(3'd2, 32'h8000_0000, 8'd40, 1'b0, {1'b1, 32'hFFFF_FFFF}, "R9");
      drive(3'd3, 32'h8000_0001, 8'd64, 1'b0, {1'b1, 32'h8000_0001}, "R10");
      drive(3'd3, 32'h0000_00F0, 8'd36, 1'b1, {1'b0, 32'h0000_000F}, "R10");
      drive(3'd6, 32'hCAFE_0001, 8'd9,  1'b1, {1'b1, 32'hCAFE_0001}, "R11");
      // Sweep: every kind code, amount, pattern and carry-in
      for (int k = 0; k < 8; k++)
         for (int ai = 0; ai < 12; ai++)
            for (int pi = 0; pi < 5; pi++)
               for (int c = 0; c < 2; c++)
                  drive(3'(k), pats[pi], amts[ai], 1'(c),
                        ref_f(3'(k), pats[pi], amts[ai], 1'(c)), req_of(3'(k), amts[ai]));
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule